// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block picks the source of each of the two ALU operands for the instruction that currently sits in the execute stage of a five-stage pipeline. For each operand it either keeps the value read from the register file or takes a result that an older instruction has produced but not yet committed. The two results that can be taken are the one held by the instruction in the memory stage and the one held by the instruction in the writeback stage. The unit compares the execute-stage source register numbers with the destination register numbers of those two older instructions and drives one two-bit mux select per operand.

The unit is purely combinational and has no state. It handles only the two most recent producers. A dependence on an instruction three or more slots older is served by the register file, which must return data written in a cycle to a read in that same cycle. A load in the memory stage has no data yet, so it is never a bypass source. Software must keep a dependent instruction out of the slot right after a load, and the unit does not stall for that case. A load that has reached writeback has its data and is bypassed like any other result.

Top module: `bypass_sel_unit`

## Requirements
- R1: An operand whose source register matches no forwardable producer gets select 2'b00 (register file).
- R2: An operand whose nonzero source register equals the memory-stage destination, with the memory-stage write enable set and the memory-stage load flag clear, gets select 2'b01 (memory-stage result).
- R3: An operand whose nonzero source register equals the writeback-stage destination, with the writeback-stage write enable set and no forwardable memory-stage match, gets select 2'b10 (writeback-stage result).
- R4: When both the memory-stage and writeback-stage producers are forwardable matches for the same operand, the select is 2'b01 (the younger result wins).
- R5: A source register number of 0 always gets select 2'b00, whatever the producers hold.
- R6: A producer whose write enable is clear never causes a bypass, even if its destination matches.
- R7: A memory-stage producer with the load flag set never gives select 2'b01. A writeback-stage match then gives 2'b10, and otherwise the select is 2'b00.
- R8: A writeback-stage producer that is a load is bypassed with select 2'b10 like any other result.
- R9: Each operand's select depends only on its own source register number and the shared producer fields. The two operands are resolved independently in the same cycle.
- R10: The select value 2'b11 is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_a | input | REG_AW | Source register number of operand A in execute |
| ex_rs_b | input | REG_AW | Source register number of operand B in execute |
| mem_rd | input | REG_AW | Destination register number of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes its destination |
| mem_is_ld | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination register number of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes its destination |
| sel_a | output | 2 | Operand A select: 00 register file, 01 memory stage, 10 writeback stage |
| sel_b | output | 2 | Operand B select, same encoding as sel_a |

## Verification
The unit holds no state, so a fault in its compare or priority logic shows on sel_a or sel_b in the same cycle as the input pattern that triggers it. Nothing carries over to later cycles. The bench therefore compares both selects against a behavioural model on every clock. It uses directed patterns for each priority and suppression case, then random traffic over a small register range so that matches, double matches and register 0 occur often. A swapped priority, a missing load or enable qualifier, or a register 0 that is not excluded then gives a wrong select within a few cycles.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } byp_sel_e;

endpackage

// File: rtl/bsu_hit.sv
// Decides whether one producer stage supplies a usable value for one source.
module bsu_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] prod_rd,
  input  logic              prod_wen,
  input  logic              prod_ready,
  output logic              hit
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic rd_equal;

  always_comb begin
    src_live = (src != ZERO_REG);
    rd_equal = (src == prod_rd);
    hit      = src_live && rd_equal && prod_wen && prod_ready;
  end

endmodule

// File: rtl/bsu_prio.sv
// Priority between the two producers: the younger (memory stage) wins.
module bsu_prio
  import bsu_pkg::*;
(
  input  logic     mem_hit,
  input  logic     wb_hit,
  output byp_sel_e sel
);

  always_comb begin
    if (mem_hit) begin
      sel = SEL_MEM;
    end else if (wb_hit) begin
      sel = SEL_WB;
    end else begin
      sel = SEL_RF;
    end
  end

endmodule

// File: rtl/bypass_sel_unit.sv
module bypass_sel_unit
  import bsu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs_a,
  input  logic [REG_AW-1:0] ex_rs_b,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_is_ld,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);

  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] src_v [NUM_OPS];
  byp_sel_e          sel_v [NUM_OPS];
  logic              mem_ready;
  logic              wb_ready;

  // Memory-stage load data does not exist yet; writeback data always does.
  always_comb begin
    mem_ready = !mem_is_ld;
    wb_ready  = 1'b1;
  end

  assign src_v[0] = ex_rs_a;
  assign src_v[1] = ex_rs_b;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    logic mem_hit;
    logic wb_hit;

    bsu_hit #(.REG_AW(REG_AW)) u_mem_hit (
      .src        (src_v[op]),
      .prod_rd    (mem_rd),
      .prod_wen   (mem_wen),
      .prod_ready (mem_ready),
      .hit        (mem_hit)
    );

    bsu_hit #(.REG_AW(REG_AW)) u_wb_hit (
      .src        (src_v[op]),
      .prod_rd    (wb_rd),
      .prod_wen   (wb_wen),
      .prod_ready (wb_ready),
      .hit        (wb_hit)
    );

    bsu_prio u_prio (
      .mem_hit (mem_hit),
      .wb_hit  (wb_hit),
      .sel     (sel_v[op])
    );
  end

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];

endmodule

// File: rtl/bsu_chk.sv
module bsu_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs_a,
  input logic [REG_AW-1:0] ex_rs_b,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_wen,
  input logic              mem_is_ld,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_wen,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);

  always_comb begin
    p_sel_legal_r10: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select 11 driven");

    p_zero_reg_r5: assert ((ex_rs_a != '0 || sel_a == 2'b00) &&
                           (ex_rs_b != '0 || sel_b == 2'b00))
      else $error("register 0 bypassed");

    p_mem_src_valid_r2: assert ((sel_a != 2'b01 || (mem_wen && !mem_is_ld && mem_rd == ex_rs_a)) &&
                                (sel_b != 2'b01 || (mem_wen && !mem_is_ld && mem_rd == ex_rs_b)))
      else $error("memory-stage select without a usable producer");

    p_wb_src_valid_r3: assert ((sel_a != 2'b10 || (wb_wen && wb_rd == ex_rs_a)) &&
                               (sel_b != 2'b10 || (wb_wen && wb_rd == ex_rs_b)))
      else $error("writeback select without a producer");

    p_younger_first_r4: assert ((sel_a != 2'b10 || !(mem_wen && !mem_is_ld && mem_rd == ex_rs_a)) &&
                                (sel_b != 2'b10 || !(mem_wen && !mem_is_ld && mem_rd == ex_rs_b)))
      else $error("older result chosen over younger");

    p_no_miss_r1: assert ((sel_a != 2'b00 || ex_rs_a == '0 ||
                           (!(mem_wen && !mem_is_ld && mem_rd == ex_rs_a) && !(wb_wen && wb_rd == ex_rs_a))) &&
                          (sel_b != 2'b00 || ex_rs_b == '0 ||
                           (!(mem_wen && !mem_is_ld && mem_rd == ex_rs_b) && !(wb_wen && wb_rd == ex_rs_b))))
      else $error("register file chosen despite a usable producer");
  end

endmodule

bind bypass_sel_unit bsu_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/bypass_sel_unit_bench.sv
module bypass_sel_unit_bench;

  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] ex_rs_a, ex_rs_b, mem_rd, wb_rd;
  logic          mem_wen, mem_is_ld, wb_wen;
  logic [1:0]    sel_a, sel_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  bypass_sel_unit #(.REG_AW(AW)) u_bypass_sel_unit (
    .ex_rs_a   (ex_rs_a),
    .ex_rs_b   (ex_rs_b),
    .mem_rd    (mem_rd),
    .mem_wen   (mem_wen),
    .mem_is_ld (mem_is_ld),
    .wb_rd     (wb_rd),
    .wb_wen    (wb_wen),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int model_sel(int src);
    if (src == 0) return 0;
    if (mem_wen && !mem_is_ld && int'(mem_rd) == src) return 1;
    if (wb_wen && int'(wb_rd) == src) return 2;
    return 0;
  endfunction

  function automatic string model_tag(int src);
    if (src == 0) return "R5";
    if (mem_wen && !mem_is_ld && int'(mem_rd) == src)
      return (wb_wen && int'(wb_rd) == src) ? "R4" : "R2";
    if (mem_wen && mem_is_ld && int'(mem_rd) == src) return "R7";
    if (wb_wen && int'(wb_rd) == src) return "R3";
    if ((!mem_wen && int'(mem_rd) == src) || (!wb_wen && int'(wb_rd) == src)) return "R6";
    return "R1";
  endfunction

  task automatic check_now(string tag);
    int ea, eb;
    string ta, tb;
    ea = model_sel(int'(ex_rs_a));
    eb = model_sel(int'(ex_rs_b));
    ta = (tag == "") ? model_tag(int'(ex_rs_a)) : tag;
    tb = (tag == "") ? model_tag(int'(ex_rs_b)) : tag;
    checks++;
    if (int'(sel_a) != ea) begin
      failures++;
      $display("FAIL %s sel_a actual=%0d expected=%0d", ta, sel_a, ea);
    end
    checks++;
    if (int'(sel_b) != eb) begin
      failures++;
      $display("FAIL %s sel_b actual=%0d expected=%0d", tb, sel_b, eb);
    end
    checks++;
    if (sel_a == 2'b11 || sel_b == 2'b11) begin
      failures++;
      $display("FAIL R10 illegal select actual=%0d/%0d expected=not 3", sel_a, sel_b);
    end
  endtask

  task automatic drive(input int a, input int b, input int mrd, input bit mw, input bit ml,
                       input int wrd, input bit ww, input string tag);
    @(posedge clk);
    ex_rs_a   <= AW'(a);
    ex_rs_b   <= AW'(b);
    mem_rd    <= AW'(mrd);
    mem_wen   <= mw;
    mem_is_ld <= ml;
    wb_rd     <= AW'(wrd);
    wb_wen    <= ww;
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ex_rs_a = '0; ex_rs_b = '0; mem_rd = '0; wb_rd = '0;
    mem_wen = 1'b0; mem_is_ld = 1'b0; wb_wen = 1'b0;
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    check_now("R1");                              // reset/idle state

    drive(3, 4, 7, 1, 0, 9, 1, "R1");             // no match
    drive(7, 4, 7, 1, 0, 9, 1, "");               // R2 on A
    drive(4, 7, 7, 1, 0, 9, 1, "");               // R2 on B
    drive(9, 3, 7, 1, 0, 9, 1, "");               // R3 on A
    drive(6, 6, 6, 1, 0, 6, 1, "R4");             // both match, younger wins
    drive(0, 0, 0, 1, 0, 0, 1, "R5");             // register 0
    drive(5, 5, 5, 0, 0, 5, 0, "R6");             // enables low
    drive(5, 8, 5, 0, 0, 8, 1, "");               // R6 on mem, R3 on B
    drive(5, 5, 5, 1, 1, 2, 1, "R7");             // load in mem, no wb
    drive(5, 5, 5, 1, 1, 5, 1, "R7");             // load in mem, wb match
    drive(12, 1, 3, 1, 0, 12, 1, "R8");           // wb load treated like ALU
    drive(3, 12, 3, 1, 0, 12, 1, "R9");           // operands resolve differently
    drive(31, 31, 31, 1, 0, 0, 1, "R2");          // top register

    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            $urandom_range(0, 3), 1'($urandom_range(0, 1)), "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule